// File: doc/BRIEF.md
# Infrared Remote Pulse Receiver

This block takes a remote-control line that has already been demodulated and synchronized to the core clock. It looks at the line only when the sampling enable `fs_tick` is high. On each sample it measures the current low run, the current high run and the time since the last falling edge. From these it recognizes an optional leader, decodes data bits and writes them into a 72-bit register, first bit at index 0. A frame ends when one of two programmable terminators fires. The first is a low run that is too long. The second is a bit cycle that is too long. When a frame ends, the block raises a completion pulse. Received data stays in place until software sends a clear pulse, which re-arms the receiver.

The block has two decoding methods. In the cycle method, each falling edge closes one bit cycle. The cycle length is compared against a mid threshold. In the phase method the bit period is fixed, and the line level is read a set number of samples after each falling edge. Two pulse outputs can be enabled separately: one marks each sampled falling edge and one marks a detected leader.

The state machine has five states:
- `ST_IDLE` goes to `ST_LEAD_LOW` on a falling edge.
- `ST_LEAD_LOW` waits for the next rising edge. If the low width is inside its window it goes to `ST_LEAD_HIGH`. If not, it goes to `ST_DATA` when a leader is optional and back to `ST_IDLE` otherwise.
- `ST_LEAD_HIGH` waits for the next falling edge. If the high width is inside its window it goes to `ST_DATA` as a leader hit. If not, it goes to `ST_DATA` when a leader is optional and to `ST_IDLE` otherwise.
- `ST_DATA` goes to `ST_DONE` when a terminator fires.
- `ST_DONE` holds until clear.
- A clear pulse returns any state to `ST_IDLE`.

Top module: `ir_pulse_rx`

## Requirements
- R1: In cycle method (`cfg_phase_mode`=0), each sampled falling edge in `ST_DATA` decodes one bit. The bit is 1 when the number of fs samples since the previous falling edge is greater than `cfg_bit_mid`, and 0 otherwise. The k-th decoded bit is written to `rx_data[k]`, and `rx_bits` counts the bits received.
- R2: In `ST_DATA`, a low run of more than `cfg_low_limit` samples ends reception. `rx_done` then goes to 1 with a one-cycle `done_irq`. The value 8'hFF disables this terminator.
- R3: In `ST_DATA`, more than `cfg_cycle_limit` samples since the last falling edge ends reception in the same way. The value 8'hFF disables this terminator.
- R4: A leader is a low run within [`cfg_lead_low_min`, `cfg_lead_low_max`] samples followed by a high run within [`cfg_lead_high_min`, `cfg_lead_high_max`]. On the falling edge that ends the leader, `leader_irq` pulses for one cycle, but only when `cfg_leader_irq_en`=1. A leader whose low run is outside its window is not accepted.
- R5: With `cfg_leader_opt`=0, a frame without a valid leader stores no bits. With `cfg_leader_opt`=1, such a frame is received, and its first falling edge starts the first bit cycle.
- R6: In phase method (`cfg_phase_mode`=1), one bit is taken when exactly `cfg_phase_half` samples have passed since the last falling edge. The bit is the line level at that sample: high gives 1, low gives 0.
- R7: `fall_irq` pulses for one cycle for each sampled falling edge of `rx_in`, and only when `cfg_fall_irq_en`=1.
- R8: `rx_bits` stops at 72, and bits that arrive after that are dropped.
- R9: While `rx_done`=1, `rx_data` and `rx_bits` do not change. A `clear` pulse sets data, count and `rx_done` to zero and returns the receiver to `ST_IDLE`.
- R10: After reset, `rx_data`, `rx_bits`, `rx_done` and all three pulse outputs are 0.
- R11: While `fs_tick` stays low, activity on `rx_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_tick | input | 1 | Sampling enable, one core cycle wide |
| rx_in | input | 1 | Demodulated remote line, idle high |
| clear | input | 1 | Clears data and count and re-arms the receiver |
| cfg_leader_irq_en | input | 1 | Enables leader pulse |
| cfg_fall_irq_en | input | 1 | Enables falling-edge pulse |
| cfg_leader_opt | input | 1 | 1: leader optional, 0: leader required |
| cfg_phase_mode | input | 1 | 1: phase method, 0: cycle method |
| cfg_low_limit | input | 8 | Excess-low threshold in samples, FF disables |
| cfg_cycle_limit | input | 8 | Maximum bit-cycle threshold in samples, FF disables |
| cfg_bit_mid | input | 8 | Cycle-method 0/1 decision threshold |
| cfg_phase_half | input | 8 | Phase-method sample offset after a falling edge |
| cfg_lead_low_min | input | 8 | Leader low window, lower bound |
| cfg_lead_low_max | input | 8 | Leader low window, upper bound |
| cfg_lead_high_min | input | 8 | Leader high window, lower bound |
| cfg_lead_high_max | input | 8 | Leader high window, upper bound |
| rx_data | output | 72 | Received bits, first bit at index 0 |
| rx_bits | output | 7 | Number of bits received |
| rx_done | output | 1 | Reception complete, held until clear |
| leader_irq | output | 1 | Leader detected pulse |
| fall_irq | output | 1 | Falling edge pulse |
| done_irq | output | 1 | Reception complete pulse |

## Verification
The falling edge that closes a leader also starts the first bit cycle. On that one sample, both `leader_irq` and `fall_irq` pulse in the same core cycle. Every frame in the stimulus table contains this moment. The bench counts cycles in which both pulses are high and expects exactly one per frame, with each pulse also counted separately. The excess-low and over-long-cycle terminators can both be armed at once, so the bench isolates each of them by disabling the other with 8'hFF.

// File: rtl/ir_rx_pkg.sv
`timescale 1ns/1ps
package ir_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LEAD_LOW  = 3'd1,
        ST_LEAD_HIGH = 3'd2,
        ST_DATA      = 3'd3,
        ST_DONE      = 3'd4
    } rx_state_e;
endpackage

// File: rtl/ir_rx_meter.sv
`timescale 1ns/1ps
// Samples the line on fs_tick and keeps low-run, high-run and
// since-last-fall counters; all saturate at their maximum.
module ir_rx_meter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_tick,
    input  logic             rx_in,
    output logic             line_now,
    output logic             edge_fall,
    output logic             edge_rise,
    output logic [CNT_W-1:0] low_cnt,
    output logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] cyc_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic line_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    assign line_now  = rx_in;
    assign edge_fall = fs_tick &  line_q & ~rx_in;
    assign edge_rise = fs_tick & ~line_q &  rx_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q   <= 1'b1;
            low_cnt  <= '0;
            high_cnt <= '0;
            cyc_cnt  <= CNT_MAX;
        end else if (fs_tick) begin
            line_q   <= rx_in;
            low_cnt  <= rx_in ? '0 : sat_inc(low_cnt);
            high_cnt <= rx_in ? sat_inc(high_cnt) : '0;
            cyc_cnt  <= edge_fall ? CNT_W'(1) : sat_inc(cyc_cnt);
        end
    end
endmodule

// File: rtl/ir_rx_fsm.sv
`timescale 1ns/1ps
module ir_rx_fsm
    import ir_rx_pkg::*;
#(
    parameter int TH_W  = 8,
    parameter int CNT_W = TH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_tick,
    input  logic             clear,
    input  logic             cfg_leader_irq_en,
    input  logic             cfg_fall_irq_en,
    input  logic             cfg_leader_opt,
    input  logic             cfg_phase_mode,
    input  logic [TH_W-1:0]  cfg_low_limit,
    input  logic [TH_W-1:0]  cfg_cycle_limit,
    input  logic [TH_W-1:0]  cfg_bit_mid,
    input  logic [TH_W-1:0]  cfg_phase_half,
    input  logic [TH_W-1:0]  cfg_lead_low_min,
    input  logic [TH_W-1:0]  cfg_lead_low_max,
    input  logic [TH_W-1:0]  cfg_lead_high_min,
    input  logic [TH_W-1:0]  cfg_lead_high_max,
    input  logic             line_now,
    input  logic             edge_fall,
    input  logic             edge_rise,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] cyc_cnt,
    output logic             shift_en,
    output logic             shift_bit,
    output logic             rx_done,
    output logic             leader_irq,
    output logic             fall_irq,
    output logic             done_irq
);
    localparam logic [TH_W-1:0] TH_OFF = {TH_W{1'b1}};

    rx_state_e state, nxt;
    logic      lead_hit, term;
    logic      low_ok, high_ok, low_hit, cyc_hit;

    function automatic logic [CNT_W-1:0] ext(input logic [TH_W-1:0] v);
        return {{(CNT_W-TH_W){1'b0}}, v};
    endfunction

    always_comb begin
        low_ok  = (low_cnt  >= ext(cfg_lead_low_min))  && (low_cnt  <= ext(cfg_lead_low_max));
        high_ok = (high_cnt >= ext(cfg_lead_high_min)) && (high_cnt <= ext(cfg_lead_high_max));
        low_hit = (cfg_low_limit   != TH_OFF) && (low_cnt > ext(cfg_low_limit));
        cyc_hit = (cfg_cycle_limit != TH_OFF) && (cyc_cnt > ext(cfg_cycle_limit));
    end

    // next state and per-sample actions
    always_comb begin
        nxt       = state;
        shift_en  = 1'b0;
        shift_bit = 1'b0;
        lead_hit  = 1'b0;
        term      = 1'b0;
        if (fs_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (edge_fall) nxt = ST_LEAD_LOW;
                end
                ST_LEAD_LOW: begin
                    if (edge_rise) begin
                        if (low_ok)              nxt = ST_LEAD_HIGH;
                        else if (cfg_leader_opt) nxt = ST_DATA;
                        else                     nxt = ST_IDLE;
                    end
                end
                ST_LEAD_HIGH: begin
                    if (edge_fall) begin
                        if (high_ok) begin
                            nxt      = ST_DATA;
                            lead_hit = 1'b1;
                        end else if (cfg_leader_opt) begin
                            nxt = ST_DATA;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (low_hit || cyc_hit) begin
                        nxt  = ST_DONE;
                        term = 1'b1;
                    end else if (!cfg_phase_mode && edge_fall) begin
                        shift_en  = 1'b1;
                        shift_bit = (cyc_cnt > ext(cfg_bit_mid));
                    end else if (cfg_phase_mode && (cyc_cnt == ext(cfg_phase_half))) begin
                        shift_en  = 1'b1;
                        shift_bit = line_now;
                    end
                end
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_IDLE;
            endcase
        end
        if (clear) begin
            nxt      = ST_IDLE;
            shift_en = 1'b0;
            lead_hit = 1'b0;
            term     = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_done    <= 1'b0;
            leader_irq <= 1'b0;
            fall_irq   <= 1'b0;
            done_irq   <= 1'b0;
        end else begin
            rx_done    <= (nxt == ST_DONE);
            leader_irq <= lead_hit & cfg_leader_irq_en;
            fall_irq   <= edge_fall & cfg_fall_irq_en;
            done_irq   <= term;
        end
    end
endmodule

// File: rtl/ir_rx_store.sv
`timescale 1ns/1ps
// Bit store: the k-th accepted bit lands at index k; count saturates.
module ir_rx_store #(
    parameter int DATA_W = 72,
    parameter int BCNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic [BCNT_W-1:0] rx_bits
);
    localparam logic [BCNT_W-1:0] FULL = BCNT_W'(DATA_W);

    logic take;
    assign take = shift_en && (rx_bits != FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rx_bits <= '0;
        else if (clear) rx_bits <= '0;
        else if (take)  rx_bits <= rx_bits + 1'b1;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  rx_data[i] <= 1'b0;
            else if (clear)                              rx_data[i] <= 1'b0;
            else if (take && (rx_bits == BCNT_W'(i)))    rx_data[i] <= shift_bit;
        end
    end
endmodule

// File: rtl/ir_pulse_rx.sv
`timescale 1ns/1ps
module ir_pulse_rx #(
    parameter int TH_W   = 8,
    parameter int DATA_W = 72,
    localparam int CNT_W  = TH_W + 1,
    localparam int BCNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              rx_in,
    input  logic              clear,
    input  logic              cfg_leader_irq_en,
    input  logic              cfg_fall_irq_en,
    input  logic              cfg_leader_opt,
    input  logic              cfg_phase_mode,
    input  logic [TH_W-1:0]   cfg_low_limit,
    input  logic [TH_W-1:0]   cfg_cycle_limit,
    input  logic [TH_W-1:0]   cfg_bit_mid,
    input  logic [TH_W-1:0]   cfg_phase_half,
    input  logic [TH_W-1:0]   cfg_lead_low_min,
    input  logic [TH_W-1:0]   cfg_lead_low_max,
    input  logic [TH_W-1:0]   cfg_lead_high_min,
    input  logic [TH_W-1:0]   cfg_lead_high_max,
    output logic [DATA_W-1:0] rx_data,
    output logic [BCNT_W-1:0] rx_bits,
    output logic              rx_done,
    output logic              leader_irq,
    output logic              fall_irq,
    output logic              done_irq
);
    logic             line_now, edge_fall, edge_rise;
    logic [CNT_W-1:0] low_cnt, high_cnt, cyc_cnt;
    logic             shift_en, shift_bit;

    ir_rx_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .rx_in(rx_in),
        .line_now(line_now), .edge_fall(edge_fall), .edge_rise(edge_rise),
        .low_cnt(low_cnt), .high_cnt(high_cnt), .cyc_cnt(cyc_cnt)
    );

    ir_rx_fsm #(.TH_W(TH_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .clear(clear),
        .cfg_leader_irq_en(cfg_leader_irq_en), .cfg_fall_irq_en(cfg_fall_irq_en),
        .cfg_leader_opt(cfg_leader_opt), .cfg_phase_mode(cfg_phase_mode),
        .cfg_low_limit(cfg_low_limit), .cfg_cycle_limit(cfg_cycle_limit),
        .cfg_bit_mid(cfg_bit_mid), .cfg_phase_half(cfg_phase_half),
        .cfg_lead_low_min(cfg_lead_low_min), .cfg_lead_low_max(cfg_lead_low_max),
        .cfg_lead_high_min(cfg_lead_high_min), .cfg_lead_high_max(cfg_lead_high_max),
        .line_now(line_now), .edge_fall(edge_fall), .edge_rise(edge_rise),
        .low_cnt(low_cnt), .high_cnt(high_cnt), .cyc_cnt(cyc_cnt),
        .shift_en(shift_en), .shift_bit(shift_bit), .rx_done(rx_done),
        .leader_irq(leader_irq), .fall_irq(fall_irq), .done_irq(done_irq)
    );

    ir_rx_store #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .shift_en(shift_en), .shift_bit(shift_bit),
        .rx_data(rx_data), .rx_bits(rx_bits)
    );
endmodule

// File: rtl/ir_pulse_rx_chk.sv
`timescale 1ns/1ps
module ir_pulse_rx_chk #(
    parameter int DATA_W = 72,
    parameter int BCNT_W = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_tick,
    input logic              clear,
    input logic              cfg_leader_irq_en,
    input logic              cfg_fall_irq_en,
    input logic [DATA_W-1:0] rx_data,
    input logic [BCNT_W-1:0] rx_bits,
    input logic              rx_done,
    input logic              leader_irq,
    input logic              fall_irq,
    input logic              done_irq
);
    assert_done_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (rx_done && !$past(rx_done)));

    assert_fall_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_irq |-> ($past(cfg_fall_irq_en) && $past(fs_tick)));

    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_irq |=> !fall_irq);

    assert_lead_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        leader_irq |-> $past(cfg_leader_irq_en));

    assert_bits_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bits <= BCNT_W'(DATA_W));

    assert_hold_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clear) |=> ($stable(rx_data) && $stable(rx_bits)));

    assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bits != $past(rx_bits)) |-> ($past(fs_tick) || $past(clear)));
endmodule

bind ir_pulse_rx ir_pulse_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .clear(clear),
    .cfg_leader_irq_en(cfg_leader_irq_en), .cfg_fall_irq_en(cfg_fall_irq_en),
    .rx_data(rx_data), .rx_bits(rx_bits), .rx_done(rx_done),
    .leader_irq(leader_irq), .fall_irq(fall_irq), .done_irq(done_irq)
);

// File: tb/ir_pulse_rx_bench.sv
`timescale 1ns/1ps
module ir_pulse_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_tick = 1'b0;
    logic        fs_run = 1'b1;
    logic [1:0]  div = 2'd0;
    logic        rx_in = 1'b1;
    logic        clear = 1'b0;
    logic        lead_en = 1'b1, fall_en = 1'b1, lead_opt = 1'b0, phase = 1'b0;
    logic [7:0]  low_lim = 8'd10, cyc_lim = 8'd20;
    logic [71:0] rx_data;
    logic [6:0]  rx_bits;
    logic        rx_done, leader_irq, fall_irq, done_irq;
    int          n_chk = 0, n_err = 0;
    int          n_lead = 0, n_fall = 0, n_done = 0, n_both = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        div     <= div + 2'd1;
        fs_tick <= fs_run && (div == 2'd3);
    end

    always @(negedge clk) begin
        if (leader_irq)             n_lead <= n_lead + 1;
        if (fall_irq)               n_fall <= n_fall + 1;
        if (done_irq)               n_done <= n_done + 1;
        if (leader_irq && fall_irq) n_both <= n_both + 1;
    end

    ir_pulse_rx u_ir_pulse_rx (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .rx_in(rx_in), .clear(clear),
        .cfg_leader_irq_en(lead_en), .cfg_fall_irq_en(fall_en),
        .cfg_leader_opt(lead_opt), .cfg_phase_mode(phase),
        .cfg_low_limit(low_lim), .cfg_cycle_limit(cyc_lim),
        .cfg_bit_mid(8'd5), .cfg_phase_half(8'd4),
        .cfg_lead_low_min(8'd12), .cfg_lead_low_max(8'd20),
        .cfg_lead_high_min(8'd6), .cfg_lead_high_max(8'd10),
        .rx_data(rx_data), .rx_bits(rx_bits), .rx_done(rx_done),
        .leader_irq(leader_irq), .fall_irq(fall_irq), .done_irq(done_irq)
    );

    // {phase, nbits, pattern}
    localparam logic [23:0] VEC [0:5] = '{
        {1'b0, 7'd8,  16'h00A5},
        {1'b0, 7'd16, 16'hFFFF},
        {1'b0, 7'd12, 16'h0000},
        {1'b1, 7'd8,  16'h003C},
        {1'b1, 7'd16, 16'hC3A1},
        {1'b0, 7'd1,  16'h0001}
    };

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx_in = lvl;
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic leader(input int low_ticks);
        hold(1'b0, low_ticks);
        hold(1'b1, 8);
    endtask

    // cycle method: low 2, high 2 (bit 0) or 6 (bit 1); stop pulse then idle
    task automatic cyc_frame(input logic [79:0] pat, input int n, input int lead_low);
        if (lead_low > 0) leader(lead_low);
        for (int i = 0; i < n; i++) begin
            hold(1'b0, 2);
            hold(1'b1, pat[i] ? 6 : 2);
        end
        hold(1'b0, 2);
        hold(1'b1, 40);
    endtask

    // phase method: fixed 8-sample period, level at sample 4 after the fall
    task automatic ph_frame(input logic [79:0] pat, input int n);
        leader(16);
        for (int i = 0; i < n; i++) begin
            hold(1'b0, 2);
            hold(pat[i], 4);
            hold(1'b1, 2);
        end
        hold(1'b1, 40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int b_lead, b_fall, b_done, b_both;
        logic [71:0] exp;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 data", rx_data, 72'd0);
        chk("R10 bits", {65'd0, rx_bits}, 72'd0);
        chk("R10 pulses", {68'd0, rx_done, leader_irq, fall_irq, done_irq}, 72'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table walk
        for (int v = 0; v < 6; v++) begin
            phase = VEC[v][23];
            pulse_clear();
            b_lead = n_lead; b_fall = n_fall; b_done = n_done; b_both = n_both;
            if (phase) ph_frame({64'd0, VEC[v][15:0]}, int'(VEC[v][22:16]));
            else       cyc_frame({64'd0, VEC[v][15:0]}, int'(VEC[v][22:16]), 16);
            exp = 72'(VEC[v][15:0]) & ((72'd1 << VEC[v][22:16]) - 72'd1);
            chk(phase ? "R6 data" : "R1 data", rx_data, exp);
            chk("R1 bits", {65'd0, rx_bits}, 72'(VEC[v][22:16]));
            chk("R3 done", {71'd0, rx_done}, 72'd1);
            chk("R3 done pulse", 72'(n_done - b_done), 72'd1);
            chk("R4 leader pulse", 72'(n_lead - b_lead), 72'd1);
            chk("R4 leader with fall", 72'(n_both - b_both), 72'd1);
            chk("R7 fall count", 72'(n_fall - b_fall),
                72'(int'(VEC[v][22:16]) + (phase ? 1 : 2)));
        end
        phase = 1'b0;

        // R2 excess low, cycle terminator off
        cyc_lim = 8'hFF;
        pulse_clear();
        leader(16);
        hold(1'b0, 2); hold(1'b1, 6);
        hold(1'b0, 2); hold(1'b1, 2);
        hold(1'b0, 2); hold(1'b1, 6);
        hold(1'b0, 30);
        chk("R2 done", {71'd0, rx_done}, 72'd1);
        chk("R2 bits", {65'd0, rx_bits}, 72'd3);
        chk("R2 data", rx_data, 72'd5);
        // R9 further activity ignored while done
        cyc_frame(80'hF, 4, 0);
        chk("R9 hold bits", {65'd0, rx_bits}, 72'd3);
        chk("R9 hold data", rx_data, 72'd5);
        pulse_clear();
        chk("R9 clear", {rx_data[63:0], rx_bits, rx_done}, 72'd0);

        // R2 and R3 disabled by all ones
        low_lim = 8'hFF;
        leader(16);
        hold(1'b0, 2); hold(1'b1, 6);
        hold(1'b0, 60);
        chk("R2 off", {71'd0, rx_done}, 72'd0);
        hold(1'b1, 300);
        chk("R3 off", {71'd0, rx_done}, 72'd0);
        chk("R3 off bits", {65'd0, rx_bits}, 72'd1);
        low_lim = 8'd10; cyc_lim = 8'd20;
        pulse_clear();
        chk("R9 rearm", {rx_data[63:0], rx_bits, rx_done}, 72'd0);

        // R5 no leader
        lead_opt = 1'b0;
        cyc_frame(80'h2D, 6, 0);
        chk("R5 required", {64'd0, rx_bits, rx_done}, 72'd0);
        lead_opt = 1'b1;
        pulse_clear();
        cyc_frame(80'h2D, 6, 0);
        chk("R5 optional data", rx_data, 72'h2D);
        chk("R5 optional bits", {65'd0, rx_bits}, 72'd6);
        lead_opt = 1'b0;

        // R4 leader too long rejected
        pulse_clear();
        cyc_frame(80'h3, 4, 25);
        chk("R4 window reject", {64'd0, rx_bits, rx_done}, 72'd0);

        // R4 / R7 pulses disabled
        lead_en = 1'b0; fall_en = 1'b0;
        pulse_clear();
        b_lead = n_lead; b_fall = n_fall;
        cyc_frame(80'h9, 4, 16);
        chk("R4 leader off", 72'(n_lead - b_lead), 72'd0);
        chk("R7 fall off", 72'(n_fall - b_fall), 72'd0);
        chk("R4 data with leader off", rx_data, 72'h9);
        lead_en = 1'b1; fall_en = 1'b1;

        // R8 cap at 72
        pulse_clear();
        begin
            logic [79:0] pat;
            pat = '0;
            for (int i = 0; i < 75; i++) pat[i] = (i % 3 == 0);
            cyc_frame(pat, 75, 16);
            chk("R8 bits", {65'd0, rx_bits}, 72'd72);
            chk("R8 data", rx_data, pat[71:0]);
        end

        // R11 no sampling without fs_tick
        pulse_clear();
        fs_run = 1'b0;
        repeat (2) @(negedge clk);
        b_fall = n_fall;
        cyc_frame(80'h5, 4, 16);
        chk("R11 bits", {64'd0, rx_bits, rx_done}, 72'd0);
        chk("R11 falls", 72'(n_fall - b_fall), 72'd0);
        fs_run = 1'b1;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule